// File: doc/BRIEF.md
# Strobe Phase Sweep Calibrator

This block tunes the output strobe delay of a source-synchronous link. It runs after a start request. First it reads the current strobe phase from the delay control register over a simple request/acknowledge register bus. It then writes every candidate delay in a parameterised range, one after another. After each write it waits a programmable settle time and starts an external pass/fail data checker, then waits for the checker's done handshake and records the verdict.

While the sweep runs, a window tracker keeps the longest unbroken run of passing settings. When the sweep ends, the calibrator writes the midpoint of that run back to the delay register. If no setting passed, it writes back the phase it read at the start and raises a fail flag. Only the strobe delay register is ever accessed. The per-bit data delays are never touched.

Top module: `strobe_sweep_cal`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o`, `fail_o`, `reg_req_o` and `test_start_o` are all low.
- R2: A `start_i` pulse seen while idle starts a run whose first bus access is a read (`reg_we_o` = 0). A `start_i` seen while a run is in progress is ignored, so the run still makes exactly one read.
- R3: Every bus access targets address `DLY_ADDR`. While `reg_req_o` is high and `reg_ack_i` is low, `reg_req_o`, `reg_we_o` and `reg_wdata_o` hold their values. A write completes on the cycle `reg_ack_i` is high. A read takes `reg_rdata_i` on that same cycle.
- R4: The sweep writes each candidate `MIN_DLY`, `MIN_DLY+STEP`, ... up to the largest value not above `MAX_DLY`, in ascending order. It issues exactly one single-cycle `test_start_o` pulse per candidate. It does not move on until `test_done_i` is high, and it samples `test_pass_i` in that cycle.
- R5: After a candidate write is acknowledged, `test_start_o` first goes high no sooner than `settle_cycles_i`+1 clock edges after the edge at which the acknowledge was taken.
- R6: The window is the longest run of consecutive passing candidates. When runs tie in length, the earliest one wins. The final write carries (first + last) / 2 of that run, rounded down.
- R7: If no candidate passes, the final write carries the value read at the start of the run, and `fail_o` goes high in the same cycle as `done_o`.
- R8: `done_o` is a one-cycle pulse issued after the final write is acknowledged, with `busy_o` low. `fail_o` keeps its value until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a calibration run (accepted only while idle) |
| settle_cycles_i | input | SETTLE_W | Wait after each delay write before the test starts |
| reg_req_o | output | 1 | Register access request, held until acknowledged |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | ADDR_W | Register address (always DLY_ADDR) |
| reg_wdata_o | output | DLY_W | Delay value to write |
| reg_rdata_i | input | DLY_W | Read data, valid with acknowledge |
| reg_ack_i | input | 1 | Access complete |
| test_start_o | output | 1 | One-cycle pulse that starts the data checker |
| test_done_i | input | 1 | Checker finished |
| test_pass_i | input | 1 | Checker verdict, valid with test_done_i |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | No passing setting found in the last run |

## Verification
The assertions check the following on every cycle:
- requests are held stable until acknowledged;
- test starts are single-cycle pulses;
- sweep writes stay inside the candidate range;
- the settle counter counts down one step per cycle;
- the tracked window never has its first point after its last;
- `done_o` never overlaps `busy_o`, and `fail_o` only rises together with `done_o`.

Some behaviours depend on the checker's verdict history and can only be shown by the bench's scenarios. These are the choice of the longest run with earliest-wins on ties, the rounded-down midpoint, the restore of the initial phase when nothing passes, the ascending write order, the minimum settle gap, and ignoring a start during a run.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_SETTLE,
        ST_KICK,
        ST_WAIT,
        ST_FINAL,
        ST_DONE
    } cal_state_e;

endpackage

// File: rtl/ssc_settle_timer.sv
module ssc_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R5: a running count drops by exactly one per cycle until reloaded
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/ssc_window_track.sv
module ssc_window_track #(
    parameter int DLY_W = 9,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rec,
    input  logic             pass,
    input  logic [DLY_W-1:0] cand,
    output logic             found,
    output logic [DLY_W-1:0] centre
);

    typedef struct packed {
        logic             in_run;
        logic [DLY_W-1:0] run_first;
        logic [LEN_W-1:0] run_len;
        logic [DLY_W-1:0] best_first;
        logic [DLY_W-1:0] best_last;
        logic [LEN_W-1:0] best_len;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [LEN_W-1:0] new_len;
    logic [DLY_W-1:0] new_first;
    logic [DLY_W:0]   span_sum;

    always_comb begin
        trk_d     = trk_q;
        new_len   = trk_q.in_run ? trk_q.run_len + LEN_W'(1) : LEN_W'(1);
        new_first = trk_q.in_run ? trk_q.run_first : cand;
        if (clear) begin
            trk_d = '0;
        end else if (rec) begin
            if (pass) begin
                trk_d.in_run    = 1'b1;
                trk_d.run_first = new_first;
                trk_d.run_len   = new_len;
                // strictly longer only: the earliest of equal runs is kept
                if (new_len > trk_q.best_len) begin
                    trk_d.best_first = new_first;
                    trk_d.best_last  = cand;
                    trk_d.best_len   = new_len;
                end
            end else begin
                trk_d.in_run  = 1'b0;
                trk_d.run_len = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign span_sum = {1'b0, trk_q.best_first} + {1'b0, trk_q.best_last};
    assign centre   = span_sum[DLY_W:1];
    assign found    = (trk_q.best_len != '0);

    // R6: a recorded window never starts after it ends
    a_r6_window_order: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (trk_q.best_first <= trk_q.best_last));

    // R6: a running streak is never shorter than zero-length while flagged
    a_r6_run_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.in_run |-> (trk_q.run_len != '0));

endmodule

// File: rtl/strobe_sweep_cal.sv
module strobe_sweep_cal
    import ssc_pkg::*;
#(
    parameter int              DLY_W    = 9,
    parameter int              MIN_DLY  = 0,
    parameter int              MAX_DLY  = 31,
    parameter int              STEP     = 1,
    parameter int              SETTLE_W = 8,
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DLY_ADDR = 8'h24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SETTLE_W-1:0] settle_cycles_i,
    output logic                reg_req_o,
    output logic                reg_we_o,
    output logic [ADDR_W-1:0]   reg_addr_o,
    output logic [DLY_W-1:0]    reg_wdata_o,
    input  logic [DLY_W-1:0]    reg_rdata_i,
    input  logic                reg_ack_i,
    output logic                test_start_o,
    input  logic                test_done_i,
    input  logic                test_pass_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                fail_o
);

    localparam int             NUM_CAND = (MAX_DLY - MIN_DLY) / STEP + 1;
    localparam int             LEN_W    = $clog2(NUM_CAND + 1);
    localparam logic [DLY_W:0] STEP_X   = (DLY_W + 1)'(STEP);
    localparam logic [DLY_W:0] MAX_X    = (DLY_W + 1)'(MAX_DLY);
    localparam logic [DLY_W-1:0] MIN_V  = DLY_W'(MIN_DLY);

    typedef struct packed {
        cal_state_e       st;
        logic [DLY_W-1:0] cand;
        logic [DLY_W-1:0] init;
        logic             fail;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             trk_clear, trk_rec, win_found;
    logic [DLY_W-1:0] win_centre;
    logic             tmr_load, tmr_expired;
    logic [DLY_W:0]   cand_next;
    logic             cand_last;

    assign cand_next = {1'b0, ctl_q.cand} + STEP_X;
    assign cand_last = (cand_next > MAX_X);

    always_comb begin
        ctl_d     = ctl_q;
        trk_clear = 1'b0;
        trk_rec   = 1'b0;
        tmr_load  = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = ST_READ;
                    ctl_d.fail = 1'b0;
                    ctl_d.cand = MIN_V;
                    trk_clear  = 1'b1;
                end
            end
            ST_READ: begin
                if (reg_ack_i) begin
                    ctl_d.init = reg_rdata_i;
                    ctl_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (reg_ack_i) begin
                    tmr_load = 1'b1;
                    ctl_d.st = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) ctl_d.st = ST_KICK;
            end
            ST_KICK: begin
                ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (test_done_i) begin
                    trk_rec = 1'b1;
                    if (cand_last) begin
                        ctl_d.st = ST_FINAL;
                    end else begin
                        ctl_d.cand = cand_next[DLY_W-1:0];
                        ctl_d.st   = ST_WRITE;
                    end
                end
            end
            ST_FINAL: begin
                if (reg_ack_i) begin
                    ctl_d.fail = !win_found;
                    ctl_d.st   = ST_DONE;
                end
            end
            ST_DONE: begin
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    ssc_settle_timer #(.CNT_W(SETTLE_W)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (settle_cycles_i),
        .expired  (tmr_expired)
    );

    ssc_window_track #(.DLY_W(DLY_W), .LEN_W(LEN_W)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (trk_clear),
        .rec    (trk_rec),
        .pass   (test_pass_i),
        .cand   (ctl_q.cand),
        .found  (win_found),
        .centre (win_centre)
    );

    assign reg_req_o    = (ctl_q.st == ST_READ) || (ctl_q.st == ST_WRITE) || (ctl_q.st == ST_FINAL);
    assign reg_we_o     = (ctl_q.st == ST_WRITE) || (ctl_q.st == ST_FINAL);
    assign reg_addr_o   = DLY_ADDR;
    assign reg_wdata_o  = (ctl_q.st == ST_FINAL) ? (win_found ? win_centre : ctl_q.init) : ctl_q.cand;
    assign test_start_o = (ctl_q.st == ST_KICK);
    assign busy_o       = (ctl_q.st != ST_IDLE) && (ctl_q.st != ST_DONE);
    assign done_o       = (ctl_q.st == ST_DONE);
    assign fail_o       = ctl_q.fail;

    // R3: a pending access keeps its request, direction and data
    a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_we_o) && $stable(reg_wdata_o)));

    // R4: the checker is started by a single-cycle pulse
    a_r4_kick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        test_start_o |=> !test_start_o);

    // R4: sweep writes stay inside the candidate range
    a_r4_cand_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WRITE) |-> ((ctl_q.cand >= MIN_V) && ({1'b0, ctl_q.cand} <= MAX_X)));

    // R8: completion is reported only when no longer busy or accessing
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !reg_req_o));

    // R7: the fail flag can only rise together with completion
    a_r7_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> done_o);

endmodule

// File: tb/strobe_sweep_cal_tb.sv
`timescale 1ns/1ps
module strobe_sweep_cal_tb;

    localparam int DLY_W = 9;
    localparam int NUM   = 32;
    localparam logic [7:0] ADDR = 8'h24;

    typedef struct packed {
        logic [31:0]      mask;
        logic [DLY_W-1:0] init;
        logic [DLY_W-1:0] expv;
        logic             fail;
        logic [7:0]       settle;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{32'h001FFC00, 9'd100, 9'd15, 1'b0, 8'd3},
        '{32'h001FF0E0, 9'd77,  9'd16, 1'b0, 8'd0},
        '{32'h00000000, 9'd300, 9'd300,1'b1, 8'd2},
        '{32'hFFFFFFFF, 9'd5,   9'd15, 1'b0, 8'd1},
        '{32'h80000000, 9'd12,  9'd31, 1'b0, 8'd7},
        '{32'h0000071C, 9'd40,  9'd3,  1'b0, 8'd4},
        '{32'hC0000003, 9'd200, 9'd0,  1'b0, 8'd0},
        '{32'h00000001, 9'd9,   9'd0,  1'b0, 8'd5},
        '{32'hFE001FC7, 9'd33,  9'd9,  1'b0, 8'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [7:0] settle_i = '0;
    logic reg_req_o, reg_we_o;
    logic [7:0] reg_addr_o;
    logic [DLY_W-1:0] reg_wdata_o;
    logic [DLY_W-1:0] reg_rdata_i = '0;
    logic reg_ack_i = 1'b0;
    logic test_start_o;
    logic test_done_i = 1'b0;
    logic test_pass_i = 1'b0;
    logic busy_o, done_o, fail_o;

    always #2.5 clk = ~clk;

    strobe_sweep_cal u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_cycles_i(settle_i),
        .reg_req_o(reg_req_o), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o),
        .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i), .reg_ack_i(reg_ack_i),
        .test_start_o(test_start_o), .test_done_i(test_done_i), .test_pass_i(test_pass_i),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
    );

    int checks = 0, failures = 0;
    int cyc = 0, n_rd = 0, n_wr = 0, n_bad_addr = 0, n_tests = 0, order_err = 0;
    int first_rd = 0, last_wr = 0, min_gap = 0, done_hi = 0, busy_bad = 0, tc = 0;
    logic [DLY_W-1:0] dreg = '0;
    logic [DLY_W-1:0] exp_cand = '0;
    logic [31:0] mask = '0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // register and checker models, driven away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            reg_ack_i = 1'b0; test_done_i = 1'b0; tc = 0;
        end else begin
            if (reg_ack_i) begin
                reg_ack_i = 1'b0;
            end else if (reg_req_o) begin
                reg_ack_i = 1'b1;
                if (reg_addr_o != ADDR) n_bad_addr++;
                if (reg_we_o) begin
                    n_wr++;
                    if (n_wr <= NUM) begin
                        if (reg_wdata_o != exp_cand) order_err++;
                        exp_cand = exp_cand + 1'b1;
                        last_wr = cyc;
                    end
                    dreg = reg_wdata_o;
                end else begin
                    n_rd++;
                    if (n_wr == 0 && n_rd == 1) first_rd = 1;
                    reg_rdata_i = dreg;
                end
            end
            if (test_done_i) test_done_i = 1'b0;
            if (test_start_o) begin
                n_tests++;
                if (cyc - last_wr < min_gap) min_gap = cyc - last_wr;
                tc = 2;
            end else if (tc > 0) begin
                tc--;
                if (tc == 0) begin
                    test_done_i = 1'b1;
                    test_pass_i = mask[dreg[4:0]];
                end
            end
            if (done_o) begin
                done_hi++;
                if (busy_o) busy_bad++;
            end
        end
    end

    task automatic run_vec(input vec_t v, input bit restart_mid, input bit prev_fail);
        int t;
        mask = v.mask; settle_i = v.settle; dreg = v.init;
        n_rd = 0; n_wr = 0; n_bad_addr = 0; n_tests = 0; order_err = 0;
        first_rd = 0; done_hi = 0; busy_bad = 0; min_gap = 1000000; exp_cand = '0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        if (prev_fail) chk(fail_o == 1'b0, "R8 fail cleared by start", fail_o, 0);
        if (restart_mid) begin
            repeat (40) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
        end
        t = 0;
        while (!done_o && t < 5000) begin
            @(negedge clk); t++;
        end
        chk(t < 5000, "R8 done reached", t, 5000);
        chk(fail_o == v.fail, "R7 fail flag at done", fail_o, v.fail);
        repeat (4) @(negedge clk);
        chk(n_rd == 1 && first_rd == 1, "R2 single leading read", n_rd, 1);
        chk(n_bad_addr == 0, "R3 strobe address only", n_bad_addr, 0);
        chk(n_wr == NUM + 1, "R4 write count", n_wr, NUM + 1);
        chk(order_err == 0, "R4 ascending candidates", order_err, 0);
        chk(n_tests == NUM, "R4 one test per candidate", n_tests, NUM);
        chk(min_gap >= v.settle + 2, "R5 settle gap", min_gap, v.settle + 2);
        chk(dreg == v.expv, v.fail ? "R7 initial phase restored" : "R6 window centre", dreg, v.expv);
        chk(done_hi == 1 && busy_bad == 0, "R8 done single pulse", done_hi, 1);
        chk(fail_o == v.fail, "R8 fail held after done", fail_o, v.fail);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy_o, done_o, fail_o, reg_req_o, test_start_o} == 5'b0, "R1 outputs in reset",
            {busy_o, done_o, fail_o, reg_req_o, test_start_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({busy_o, done_o, fail_o, reg_req_o, test_start_o} == 5'b0, "R1 idle after reset",
            {busy_o, done_o, fail_o, reg_req_o, test_start_o}, 0);
        for (int i = 0; i < 9; i++) begin
            run_vec(VECS[i], 1'b0, (i > 0) ? VECS[i-1].fail : 1'b0);
        end
        // R2: start pulse during a run is ignored
        run_vec(VECS[0], 1'b1, 1'b0);
        // R7 then R8: failing run followed by a passing one clears the flag
        run_vec(VECS[2], 1'b0, 1'b0);
        run_vec(VECS[5], 1'b1, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule